// File: doc/BRIEF.md
# Video DRAM bus cycle decoder

This block watches a sampled copy of an active-low, row/column multiplexed DRAM control bus and works out which memory cycle each group of strobe edges forms. It never drives the bus. A 16-bit sample word arrives with a valid strobe. The block compares each valid sample with the previous valid one to find falling strobe edges. The order of those edges tells the cycle apart: a normal read, a normal write, a read-transfer, or a refresh where the column strobe falls before the row strobe.

For each address-carrying cycle the block captures the 8-bit row and column phases from the scattered address pins and joins them into a 16-bit raw address, with the row in the upper byte. It also reorders the raw address into the logical video address. Each decoded cycle produces one event record, marked by a single-cycle valid pulse.

Top module: `vdram_cycle_decoder`

## Requirements
- R1: While reset is high and in the cycle after it, `evt_vld_o` is 0, and `evt_raw_o` and `evt_log_o` read 0. The first valid sample after reset only primes edge detection and yields no event.
- R2: A sample with `sample_vld_i` low is ignored. It does not change the decoder state, and it is not remembered as the previous sample for edge detection.
- R3: In idle, a row-strobe fall (bit 12, 1 to 0) with output-enable (bit 14) high starts a RAM cycle. The next column-strobe fall (bit 1) latches the column. A following output-enable fall then reports kind 2'b00 (read) with raw address {row, column}.
- R4: In a latched RAM cycle, a write-enable fall (bit 13) reports kind 2'b01 (write) with raw address {row, column}.
- R5: In idle, a row-strobe fall with output-enable low starts a read-transfer. The next column-strobe fall reports kind 2'b10 immediately, with raw address {row, column}.
- R6: In idle, a column-strobe fall with output-enable high and no row-strobe fall arms a pending refresh. The next row-strobe fall reports kind 2'b11 with raw address 0.
- R7: In idle, a column-strobe fall with output-enable low is ignored. A later row-strobe fall starts an ordinary RAM cycle and does not report a refresh.
- R8: The 8-bit multiplexed address is taken as follows: sample bits 5:2 give address bits 3:0, sample bits 11:9 give address bits 6:4, and sample bit 6 gives address bit 7. Sample bits 0, 7, 8 and 15 have no effect.
- R9: `evt_log_o` reorders the raw address. Logical bits 1:0 equal raw bits 1:0, logical bits 9:2 equal raw bits 15:8, and logical bits 15:10 equal raw bits 7:2.
- R10: When two strobes fall in the same sample, a row-strobe fall in idle takes precedence over a column-strobe fall, and the column-strobe fall is dropped. In a latched RAM cycle, an output-enable fall takes precedence over a write-enable fall, so the cycle is reported as a read.
- R11: An event appears on the outputs in the clock cycle after the sample that completes it. `evt_vld_o` is high for exactly that one cycle, and every event returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 16 | Sampled bus word (strobes active low) |
| sample_vld_i | input | 1 | Sample word is valid this cycle |
| evt_vld_o | output | 1 | One-cycle pulse marking a decoded cycle |
| evt_kind_o | output | 2 | 00 read, 01 write, 10 read-transfer, 11 refresh |
| evt_raw_o | output | 16 | Row byte above column byte |
| evt_log_o | output | 16 | Reordered logical video address |

## Verification
Two kinds of strobe falls can arrive in the same sample. In idle, the row strobe and column strobe can fall together. While a RAM cycle waits for its data phase, output-enable and write-enable can fall together. The bench provokes both on purpose. It then checks the result against hand-worked values: the joint row/column fall must lead to a RAM cycle that needs a second column fall and reports no refresh, and the joint data-strobe fall must be reported as a read. A behavioural reference model also scores a long biased-random run, where such collisions occur often.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

    localparam int SMP_W   = 16;
    localparam int MUX_W   = 8;
    localparam int VADDR_W = 2 * MUX_W;
    localparam int NSTB    = 4;

    localparam int POS_CAS = 1;
    localparam int POS_RAS = 12;
    localparam int POS_WE  = 13;
    localparam int POS_OE  = 14;

    typedef enum logic [1:0] {
        EV_READ    = 2'b00,
        EV_WRITE   = 2'b01,
        EV_XFER    = 2'b10,
        EV_REFRESH = 2'b11
    } evt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_PEND_REF,
        ST_WAIT_RW
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic we;
        logic ras;
        logic cas;
    } strobe_t;

    typedef struct packed {
        logic               vld;
        evt_kind_e          kind;
        logic [VADDR_W-1:0] raw;
    } evt_req_t;

    function automatic strobe_t pick_strobes(input logic [SMP_W-1:0] s);
        strobe_t t;
        t.oe  = s[POS_OE];
        t.we  = s[POS_WE];
        t.ras = s[POS_RAS];
        t.cas = s[POS_CAS];
        return t;
    endfunction

    function automatic logic [MUX_W-1:0] mux_addr(input logic [SMP_W-1:0] s);
        return {s[6], s[11:9], s[5:2]};
    endfunction

    function automatic int remap_src(input int i);
        if (i < 2)
            return i;
        else if (i < 10)
            return i + 6;
        else
            return i - 8;
    endfunction

endpackage

// File: rtl/vdec_edge.sv
module vdec_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (vld_i) begin
            prev_q   <= lvl_i;
            primed_q <= 1'b1;
        end
    end

    for (genvar b = 0; b < N; b++) begin : g_bit
        assign fall_o[b] = vld_i & primed_q & prev_q[b] & ~lvl_i[b];
    end
endmodule

// File: rtl/vdec_seq.sv
module vdec_seq
    import vdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  strobe_t          lvl_i,
    input  strobe_t          fall_i,
    input  logic [MUX_W-1:0] maddr_i,
    output evt_req_t         req_o
);
    seq_state_e         st_q, st_d;
    logic [MUX_W-1:0]   row_q, row_d;
    logic               ram_q, ram_d;
    logic [VADDR_W-1:0] addr_q, addr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            row_q  <= '0;
            ram_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            st_q   <= st_d;
            row_q  <= row_d;
            ram_q  <= ram_d;
            addr_q <= addr_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        row_d  = row_q;
        ram_d  = ram_q;
        addr_d = addr_q;
        req_o  = '0;
        if (vld_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (fall_i.ras) begin
                        st_d  = ST_ROW;
                        row_d = maddr_i;
                        ram_d = lvl_i.oe;
                    end else if (fall_i.cas && lvl_i.oe) begin
                        st_d = ST_PEND_REF;
                    end
                end
                ST_ROW: begin
                    if (fall_i.cas) begin
                        if (ram_q) begin
                            st_d   = ST_WAIT_RW;
                            addr_d = {row_q, maddr_i};
                        end else begin
                            st_d       = ST_IDLE;
                            req_o.vld  = 1'b1;
                            req_o.kind = EV_XFER;
                            req_o.raw  = {row_q, maddr_i};
                        end
                    end
                end
                ST_PEND_REF: begin
                    if (fall_i.ras) begin
                        st_d       = ST_IDLE;
                        req_o.vld  = 1'b1;
                        req_o.kind = EV_REFRESH;
                    end
                end
                ST_WAIT_RW: begin
                    if (fall_i.oe) begin
                        st_d       = ST_IDLE;
                        req_o.vld  = 1'b1;
                        req_o.kind = EV_READ;
                        req_o.raw  = addr_q;
                    end else if (fall_i.we) begin
                        st_d       = ST_IDLE;
                        req_o.vld  = 1'b1;
                        req_o.kind = EV_WRITE;
                        req_o.raw  = addr_q;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vdec_remap.sv
module vdec_remap #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] log_o
);
    for (genvar i = 0; i < W; i++) begin : g_map
        localparam int SRC = vdec_pkg::remap_src(i);
        assign log_o[i] = raw_i[SRC];
    end
endmodule

// File: rtl/vdram_cycle_decoder.sv
module vdram_cycle_decoder
    import vdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SMP_W-1:0]   sample_i,
    input  logic               sample_vld_i,
    output logic               evt_vld_o,
    output logic [1:0]         evt_kind_o,
    output logic [VADDR_W-1:0] evt_raw_o,
    output logic [VADDR_W-1:0] evt_log_o
);
    strobe_t            lvl, fall;
    logic [MUX_W-1:0]   maddr;
    evt_req_t           req;
    logic [VADDR_W-1:0] log_addr;
    logic               unused_bits;

    assign lvl         = pick_strobes(sample_i);
    assign maddr       = mux_addr(sample_i);
    assign unused_bits = ^{sample_i[15], sample_i[8:7], sample_i[0]};

    vdec_edge #(.N(NSTB)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (sample_vld_i),
        .lvl_i  (lvl),
        .fall_o (fall)
    );

    vdec_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (sample_vld_i),
        .lvl_i   (lvl),
        .fall_i  (fall),
        .maddr_i (maddr),
        .req_o   (req)
    );

    vdec_remap #(.W(VADDR_W)) u_remap (
        .raw_i (req.raw),
        .log_o (log_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_vld_o  <= 1'b0;
            evt_kind_o <= '0;
            evt_raw_o  <= '0;
            evt_log_o  <= '0;
        end else begin
            evt_vld_o <= req.vld;
            if (req.vld) begin
                evt_kind_o <= req.kind;
                evt_raw_o  <= req.raw;
                evt_log_o  <= log_addr;
            end
        end
    end
endmodule

// File: rtl/vdec_checker.sv
module vdec_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] sample_i,
    input logic        sample_vld_i,
    input logic        evt_vld_o,
    input logic [1:0]  evt_kind_o,
    input logic [15:0] evt_raw_o,
    input logic [15:0] evt_log_o
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) rst |=> !evt_vld_o); // R1
    AST_EVT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) evt_vld_o |-> $past(sample_vld_i)); // R2
    AST_READ_ON_OE_LOW: assert property (@(posedge clk) disable iff (rst) (evt_vld_o && evt_kind_o == 2'b00) |-> !$past(sample_i[14])); // R3
    AST_WRITE_ON_WE_LOW: assert property (@(posedge clk) disable iff (rst) (evt_vld_o && evt_kind_o == 2'b01) |-> !$past(sample_i[13])); // R4
    AST_XFER_ON_CAS_LOW: assert property (@(posedge clk) disable iff (rst) (evt_vld_o && evt_kind_o == 2'b10) |-> !$past(sample_i[1])); // R5
    AST_REFRESH_NO_ADDR: assert property (@(posedge clk) disable iff (rst) (evt_vld_o && evt_kind_o == 2'b11) |-> (evt_raw_o == 16'h0 && !$past(sample_i[12]))); // R6
    AST_REMAP_FIELDS: assert property (@(posedge clk) disable iff (rst) evt_vld_o |-> (evt_log_o[1:0] == evt_raw_o[1:0] && evt_log_o[9:2] == evt_raw_o[15:8] && evt_log_o[15:10] == evt_raw_o[7:2])); // R9
endmodule

bind vdram_cycle_decoder vdec_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .evt_vld_o    (evt_vld_o),
    .evt_kind_o   (evt_kind_o),
    .evt_raw_o    (evt_raw_o),
    .evt_log_o    (evt_log_o)
);

// File: tb/vdram_cycle_decoder_test.sv
`timescale 1ns/1ps
module vdram_cycle_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] smp = 16'hFFFF;
    logic        smp_vld = 1'b0;
    logic        evt_vld_o;
    logic [1:0]  evt_kind_o;
    logic [15:0] evt_raw_o, evt_log_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vdram_cycle_decoder uut (
        .clk(clk), .rst(rst), .sample_i(smp), .sample_vld_i(smp_vld),
        .evt_vld_o(evt_vld_o), .evt_kind_o(evt_kind_o),
        .evt_raw_o(evt_raw_o), .evt_log_o(evt_log_o)
    );

    function automatic int logical_of(input int raw);
        return (raw % 4) + (((raw / 256) % 256) * 4) + (((raw / 4) % 64) * 1024);
    endfunction

    function automatic logic [15:0] mk(input bit r, input bit c, input bit o, input bit w,
                                       input logic [7:0] a);
        logic [15:0] s;
        s = 16'($urandom) & 16'h8181;
        s[1] = c; s[12] = r; s[13] = w; s[14] = o;
        s[5:2] = a[3:0]; s[11:9] = a[6:4]; s[6] = a[7];
        return s;
    endfunction

    // behavioural reference model
    int m_prev, m_st, m_row, m_addr;
    bit m_primed, m_ram;
    bit exp_vld;
    int exp_kind, exp_raw, exp_log;

    always @(posedge clk) begin
        int cur, ma;
        bit fr, fc, fo, fw, oe_hi;
        if (rst) begin
            m_primed = 0; m_st = 0; exp_vld = 0;
            exp_kind = 0; exp_raw = 0; exp_log = 0;
        end else begin
            exp_vld = 0;
            if (smp_vld) begin
                cur = int'(smp);
                fr = m_primed && ((m_prev >> 12) & 1) == 1 && ((cur >> 12) & 1) == 0;
                fc = m_primed && ((m_prev >> 1) & 1) == 1 && ((cur >> 1) & 1) == 0;
                fw = m_primed && ((m_prev >> 13) & 1) == 1 && ((cur >> 13) & 1) == 0;
                fo = m_primed && ((m_prev >> 14) & 1) == 1 && ((cur >> 14) & 1) == 0;
                oe_hi = ((cur >> 14) & 1) == 1;
                ma = ((cur >> 2) & 15) + (((cur >> 9) & 7) * 16) + (((cur >> 6) & 1) * 128);
                if (m_st == 0) begin
                    if (fr) begin m_st = 1; m_row = ma; m_ram = oe_hi; end
                    else if (fc && oe_hi) m_st = 2;
                end else if (m_st == 1) begin
                    if (fc) begin
                        if (m_ram) begin m_st = 3; m_addr = m_row * 256 + ma; end
                        else begin
                            m_st = 0; exp_vld = 1; exp_kind = 2; exp_raw = m_row * 256 + ma;
                        end
                    end
                end else if (m_st == 2) begin
                    if (fr) begin m_st = 0; exp_vld = 1; exp_kind = 3; exp_raw = 0; end
                end else begin
                    if (fo) begin m_st = 0; exp_vld = 1; exp_kind = 0; exp_raw = m_addr; end
                    else if (fw) begin m_st = 0; exp_vld = 1; exp_kind = 1; exp_raw = m_addr; end
                end
                if (exp_vld) exp_log = logical_of(exp_raw);
                m_prev = cur; m_primed = 1;
            end
        end
    end

    // compare against model every clock (R11 timing and pulse width)
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (evt_vld_o !== exp_vld) begin
                n_bad++;
                $display("FAIL R11 model vld: got %0b expected %0b", evt_vld_o, exp_vld);
            end else if (exp_vld) begin
                n_cmp++;
                if (int'(evt_kind_o) != exp_kind || int'(evt_raw_o) != exp_raw ||
                    int'(evt_log_o) != exp_log) begin
                    n_bad++;
                    $display("FAIL R11 model record: got %0d/%h/%h expected %0d/%h/%h",
                             evt_kind_o, evt_raw_o, evt_log_o, exp_kind, exp_raw, exp_log);
                end
            end
        end
    end

    task automatic step(input bit r, input bit c, input bit o, input bit w,
                        input logic [7:0] a, input bit v = 1'b1);
        smp = mk(r, c, o, w, a);
        smp_vld = v;
        @(negedge clk);
    endtask

    task automatic chk_none(input string tag);
        n_cmp++;
        if (evt_vld_o !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: evt_vld got %0b expected 0", tag, evt_vld_o);
        end
    endtask

    task automatic chk_evt(input logic [1:0] k, input logic [15:0] raw, input string tag);
        logic [15:0] lg;
        lg = 16'(logical_of(int'(raw)));
        n_cmp++;
        if (evt_vld_o !== 1'b1 || evt_kind_o !== k || evt_raw_o !== raw || evt_log_o !== lg) begin
            n_bad++;
            $display("FAIL %s: got v%0b k%0d raw %h log %h expected v1 k%0d raw %h log %h",
                     tag, evt_vld_o, evt_kind_o, evt_raw_o, evt_log_o, k, raw, lg);
        end
    endtask

    task automatic idle();
        step(1, 1, 1, 1, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (evt_vld_o !== 1'b0 || evt_raw_o !== 16'h0 || evt_log_o !== 16'h0) begin
            n_bad++;
            $display("FAIL R1 reset state: v%0b raw %h log %h expected 0 0 0",
                     evt_vld_o, evt_raw_o, evt_log_o);
        end
        rst = 1'b0;
        step(0, 0, 0, 0, 8'hFF);       // R1 first sample only primes
        chk_none("R1 priming sample");
        idle();
        chk_none("R1 rise only");

        // R3 + R9 read with hand-worked values
        step(0, 1, 1, 1, 8'hA5); chk_none("R3 row phase");
        step(0, 0, 1, 1, 8'h3C); chk_none("R3 column phase");
        step(0, 0, 0, 1, 8'h00);
        chk_evt(2'b00, 16'hA53C, "R3 read");
        n_cmp++;
        if (evt_log_o !== 16'h3E94) begin
            n_bad++;
            $display("FAIL R9 logical: got %h expected 3E94", evt_log_o);
        end
        idle(); chk_none("R11 single pulse");

        // R4 write
        step(0, 1, 1, 1, 8'h12);
        step(0, 0, 1, 1, 8'h81);
        step(0, 0, 1, 0, 8'h00);
        chk_evt(2'b01, 16'h1281, "R4 write");
        idle();

        // R5 read-transfer
        step(0, 1, 0, 1, 8'h7E); chk_none("R5 row phase");
        step(0, 0, 0, 1, 8'h01);
        chk_evt(2'b10, 16'h7E01, "R5 transfer");
        idle();

        // R6 refresh
        step(1, 0, 1, 1, 8'h55); chk_none("R6 cas first");
        step(0, 0, 1, 1, 8'h66);
        chk_evt(2'b11, 16'h0000, "R6 refresh");
        idle();

        // R7 cas fall with oe low ignored
        step(1, 0, 0, 1, 8'h00); chk_none("R7 cas oe low");
        idle();
        step(0, 1, 1, 1, 8'hC3); chk_none("R7 no refresh");
        step(0, 0, 1, 1, 8'h4B);
        step(0, 0, 0, 1, 8'h00);
        chk_evt(2'b00, 16'hC34B, "R7 ram cycle");
        idle();

        // R2 invalid sample ignored
        step(0, 1, 1, 1, 8'h21);
        step(0, 0, 1, 1, 8'h43);
        step(0, 0, 0, 0, 8'h00, 1'b0); chk_none("R2 invalid sample");
        step(0, 0, 1, 1, 8'h43); chk_none("R2 not remembered");
        step(0, 0, 0, 1, 8'h00);
        chk_evt(2'b00, 16'h2143, "R2 read after gap");
        idle();

        // R10 joint ras+cas fall in idle
        step(0, 0, 1, 1, 8'h5A); chk_none("R10 joint ras cas");
        step(0, 1, 1, 1, 8'h00); chk_none("R10 cas rise");
        step(0, 0, 1, 1, 8'hE7); chk_none("R10 column");
        step(0, 0, 0, 1, 8'h00);
        chk_evt(2'b00, 16'h5AE7, "R10 ras wins");
        idle();

        // R10 joint oe+we fall
        step(0, 1, 1, 1, 8'h9C);
        step(0, 0, 1, 1, 8'h36);
        step(0, 0, 0, 0, 8'h00);
        chk_evt(2'b00, 16'h9C36, "R10 read wins");
        idle();

        // R8 walking address pins
        for (int k = 0; k < 8; k++) begin
            logic [7:0] rw, cl;
            rw = 8'(1 << k);
            cl = ~rw;
            step(0, 1, 1, 1, rw);
            step(0, 0, 1, 1, cl);
            step(0, 0, 0, 1, 8'h00);
            chk_evt(2'b00, {rw, cl}, "R8 address pin");
            idle();
        end

        // biased random traffic checked by the model
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 4) != 0, 8'($urandom), ($urandom % 8) != 0);
        end
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule